// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit timer/counter with a second 16-bit register that serves as a reload value or as a capture target. Besides it sit a count pin, a trigger pin, a one-cycle baud tick output, a clock-out pin with its own drive enable, and two sticky flags. Software reaches the count, the reload/capture register and a control word through a small write/read register port. Reads are combinational.

The control word picks the mode. In capture mode, a trigger edge snapshots the count. In auto-reload mode the count either runs up only or runs up and down, with the trigger pin level setting the direction. Two generator modes produce a baud tick or a square wave. Both reload on every wrap and leave the overflow flag alone. The count advances on a prescaled internal tick or on falling edges of the count pin. Both pins pass through a two-flop synchronizer and an extra edge-detect flop, so a pin edge acts on the count on the third clock edge after the pin changes.

Top module: `multi_timer16`

## Requirements
- R1: Register port, with all registers at 0 after reset. Address 0 is the count, address 1 the reload/capture register, address 2 the control word. The control bits are: bit0 run, bit1 count-pin source, bit2 fast prescale, bit3 trigger enable, bit4 capture mode, bit5 up/down mode, bit6 baud mode, bit7 clock-out mode. Bit8 is the overflow flag and bit9 the external flag. Reads return the addressed register at once.
- R2: With run set and the count-pin source clear, the count advances once every 12 clocks, or once every 6 clocks with fast prescale set. With run clear the count holds.
- R3: With the count-pin source set, each falling edge of the count pin advances the count by one. A rising edge does nothing.
- R4: In capture mode with the trigger enable set, a trigger-pin falling edge copies the count into the reload/capture register and sets the external flag, and the count keeps its value. An increment at FFFFh wraps to 0000h and sets the overflow flag.
- R5: In up-only auto-reload (modes 4..7 clear), an increment at FFFFh loads the reload value and sets the overflow flag. With the trigger enable set, a trigger-pin falling edge loads the reload value and sets the external flag. With it clear, the edge has no effect.
- R6: In up/down mode with the trigger pin high, the count rises. An increment at FFFFh loads the reload value, sets the overflow flag and toggles the external flag.
- R7: In up/down mode with the trigger pin low, the count falls. A decrement while the count equals the reload value loads FFFFh, sets the overflow flag and toggles the external flag. Trigger edges never set the external flag in this mode.
- R8: In baud mode the count advances every 2 clocks and an increment at FFFFh loads the reload value. The baud tick is high for exactly the one cycle after such a wrap, and the overflow flag is not set. A trigger falling edge with the trigger enable set still sets the external flag.
- R9: In clock-out mode the count-pin drive enable is high. The count advances every 2 clocks and reloads on wrap without setting the overflow flag. The clock-out pin toggles on each wrap.
- R10: Both flags stay set until a control write carries 0 in the flag's bit. Writing 1 has no effect. A hardware set in the same cycle as a clearing write wins.
- R11: A software write of the count takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the addressed register |
| countPinIn | input | 1 | Count pin input |
| trigPinIn | input | 1 | Trigger pin input |
| countPinOut | output | 1 | Clock-out square wave |
| countPinOe | output | 1 | Drive enable for the count pin |
| baudTick | output | 1 | One-cycle pulse per wrap in baud mode |
| ovfFlag | output | 1 | Sticky overflow flag |
| extFlag | output | 1 | Sticky external flag |

## Verification
The bench runs random up/down walks with the direction re-chosen after every step. The walks cover both wrap points, the external-flag toggle, and trigger falls that must not set the flag. A design that wraps down to 0000h or sets the flag on a trigger edge diverges from the model there.

In baud mode, random reload values check each step, each wrap and each tick pulse. This catches an off-by-one wrap value, a missing or double tick, or a stray overflow flag.

Directed cases aim the following at the same clock edge:
- a count write against an increment;
- a flag-clearing write against a hardware set.

A design with the priority reversed shows a count one too high or a lost flag. Capture wrapping to 0000h rather than to the reload value is checked as well.

// File: rtl/multi_timer16_pkg.sv
package multi_timer16_pkg;

  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_CTRL   = 2'd2
  } tmrAddr_t;

  localparam int CTL_RUN   = 0;
  localparam int CTL_CPIN  = 1;
  localparam int CTL_FAST  = 2;
  localparam int CTL_EXTEN = 3;
  localparam int CTL_CAP   = 4;
  localparam int CTL_UPDN  = 5;
  localparam int CTL_BAUD  = 6;
  localparam int CTL_CLKO  = 7;
  localparam int CTL_OVF   = 8;
  localparam int CTL_EXT   = 9;
  localparam int CTL_BITS  = 8;

  typedef struct packed {
    logic inc;
    logic dec;
    logic wrapReload;
    logic extReload;
    logic capture;
    logic extSet;
    logic udMode;
    logic genMode;
    logic baudEn;
    logic toggleEn;
  } tmrStrobe_t;

endpackage

// File: rtl/multi_timer16_ctrl.sv
module multi_timer16_ctrl
  import multi_timer16_pkg::*;
#(
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 6,
  parameter int PRE_GEN     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlWr,
  input  logic [CTL_BITS-1:0] ctlData,
  input  logic                countPinIn,
  input  logic                trigPinIn,
  output logic [CTL_BITS-1:0] ctlQ,
  output tmrStrobe_t          strobe
);

  localparam int PW = $clog2(PRE_SLOW + 1);
  localparam logic [PW-1:0] LIM_SLOW = PW'(PRE_SLOW - 1);
  localparam logic [PW-1:0] LIM_FAST = PW'(PRE_FAST - 1);
  localparam logic [PW-1:0] LIM_GEN  = PW'(PRE_GEN - 1);

  logic [1:0] pinRaw;
  logic [1:0] pinLevel;
  logic [1:0] pinFall;

  assign pinRaw = {trigPinIn, countPinIn};

  // one synchronizer plus edge flop per pin
  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES:0] syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-1:0], pinRaw[g]};
    end
    assign pinLevel[g] = syncQ[SYNC_STAGES-1];
    assign pinFall[g]  = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctlQ <= '0;
    else if (ctlWr) ctlQ <= ctlData;
  end

  logic genM, udM, capM, run;
  logic [PW-1:0] preCnt;
  logic [PW-1:0] preLim;
  logic preTick, tick, trigLevel, trigFall, cntFall;

  assign run       = ctlQ[CTL_RUN];
  assign genM      = ctlQ[CTL_BAUD] | ctlQ[CTL_CLKO];
  assign udM       = ~genM & ctlQ[CTL_UPDN];
  assign capM      = ~genM & ~udM & ctlQ[CTL_CAP];
  assign trigLevel = pinLevel[1];
  assign trigFall  = pinFall[1];
  assign cntFall   = pinFall[0];

  always_comb begin
    if (genM)                 preLim = LIM_GEN;
    else if (ctlQ[CTL_FAST])  preLim = LIM_FAST;
    else                      preLim = LIM_SLOW;
  end

  assign preTick = run & (preCnt >= preLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          preCnt <= '0;
    else if (!run || preCnt >= preLim)  preCnt <= '0;
    else                                preCnt <= preCnt + 1'b1;
  end

  assign tick = genM ? preTick : (ctlQ[CTL_CPIN] ? (run & cntFall) : preTick);

  always_comb begin
    strobe            = '0;
    strobe.inc        = tick & (~udM | trigLevel);
    strobe.dec        = tick & udM & ~trigLevel;
    strobe.wrapReload = ~capM;
    strobe.extReload  = ~genM & ~udM & ~capM & ctlQ[CTL_EXTEN] & trigFall;
    strobe.capture    = capM & ctlQ[CTL_EXTEN] & trigFall;
    strobe.extSet     = ~udM & ctlQ[CTL_EXTEN] & trigFall;
    strobe.udMode     = udM;
    strobe.genMode    = genM;
    strobe.baudEn     = ctlQ[CTL_BAUD];
    strobe.toggleEn   = ctlQ[CTL_CLKO];
  end

endmodule

// File: rtl/multi_timer16_dp.sv
module multi_timer16_dp
  import multi_timer16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             cntWr,
  input  logic             rldWr,
  input  logic             flagWr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countQ,
  output logic [WIDTH-1:0] reloadQ,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             baudTick,
  output logic             clkOut
);

  localparam logic [WIDTH-1:0] MAXV = '1;

  logic atMax, atRld, overflow, underflow, wrapEvt;
  logic ovfNext, extNext;

  assign atMax     = (countQ == MAXV);
  assign atRld     = (countQ == reloadQ);
  assign overflow  = strobe.inc & atMax & ~cntWr & ~strobe.extReload;
  assign underflow = strobe.dec & atRld & ~cntWr;
  assign wrapEvt   = overflow | underflow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                countQ <= '0;
    else if (cntWr)           countQ <= wrData;
    else if (strobe.extReload) countQ <= reloadQ;
    else if (strobe.inc)      countQ <= atMax ? (strobe.wrapReload ? reloadQ : '0) : countQ + 1'b1;
    else if (strobe.dec)      countQ <= atRld ? MAXV : countQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               reloadQ <= '0;
    else if (rldWr)          reloadQ <= wrData;
    else if (strobe.capture) reloadQ <= countQ;
  end

  always_comb begin
    ovfNext = (flagWr && !wrData[CTL_OVF]) ? 1'b0 : ovfFlag;
    extNext = (flagWr && !wrData[CTL_EXT]) ? 1'b0 : extFlag;
    if (wrapEvt && !strobe.genMode) ovfNext = 1'b1;
    if (strobe.udMode) begin
      if (wrapEvt) extNext = ~extFlag;
    end else if (strobe.extSet) begin
      extNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      extFlag  <= 1'b0;
      baudTick <= 1'b0;
      clkOut   <= 1'b0;
    end else begin
      ovfFlag  <= ovfNext;
      extFlag  <= extNext;
      baudTick <= strobe.baudEn & overflow;
      if (strobe.toggleEn && overflow) clkOut <= ~clkOut;
    end
  end

endmodule

// File: rtl/multi_timer16.sv
module multi_timer16
  import multi_timer16_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 6,
  parameter int PRE_GEN     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic             countPinIn,
  input  logic             trigPinIn,
  output logic             countPinOut,
  output logic             countPinOe,
  output logic             baudTick,
  output logic             ovfFlag,
  output logic             extFlag
);

  logic [CTL_BITS-1:0] ctlQ;
  logic [WIDTH-1:0]    countQ, reloadQ;
  logic                cntWr, rldWr, ctlWr, clkOut;
  tmrStrobe_t          strobe;

  assign cntWr = regWrEn && (regAddr == ADDR_COUNT);
  assign rldWr = regWrEn && (regAddr == ADDR_RELOAD);
  assign ctlWr = regWrEn && (regAddr == ADDR_CTRL);

  multi_timer16_ctrl #(
    .PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST),
    .PRE_GEN(PRE_GEN), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr),
    .ctlData(regWrData[CTL_BITS-1:0]),
    .countPinIn(countPinIn), .trigPinIn(trigPinIn),
    .ctlQ(ctlQ), .strobe(strobe)
  );

  multi_timer16_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntWr(cntWr), .rldWr(rldWr), .flagWr(ctlWr), .wrData(regWrData),
    .countQ(countQ), .reloadQ(reloadQ),
    .ovfFlag(ovfFlag), .extFlag(extFlag),
    .baudTick(baudTick), .clkOut(clkOut)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_COUNT:  regRdData = countQ;
      ADDR_RELOAD: regRdData = reloadQ;
      ADDR_CTRL: begin
        regRdData[CTL_BITS-1:0] = ctlQ;
        regRdData[CTL_OVF]      = ovfFlag;
        regRdData[CTL_EXT]      = extFlag;
      end
      default: regRdData = '0;
    endcase
  end

  assign countPinOut = clkOut;
  assign countPinOe  = ctlQ[CTL_CLKO];

endmodule

// File: rtl/multi_timer16_chk.sv
module multi_timer16_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [WIDTH-1:0] regWrData,
  input logic [WIDTH-1:0] countQ,
  input logic [7:0]       ctlQ,
  input logic             ovfFlag,
  input logic             extFlag,
  input logic             baudTick,
  input logic             countPinOut
);

  logic genNow, udNow, ovfClr, extClr;
  assign genNow = ctlQ[6] | ctlQ[7];
  assign udNow  = ctlQ[5] & ~genNow;
  assign ovfClr = regWrEn && regAddr == 2'd2 && !regWrData[8];
  assign extClr = regWrEn && regAddr == 2'd2 && !regWrData[9];

  AST_COUNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0) |=> countQ == $past(regWrData)); // R11

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R10

  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (extFlag && !extClr && !udNow) |=> extFlag); // R10

  AST_GEN_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (genNow && !ovfFlag) |=> !ovfFlag); // R8

  AST_BAUD_AFTER_MAX: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> $past(countQ) == {WIDTH{1'b1}}); // R8

  AST_BAUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick); // R8

  AST_CLKOUT_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(countPinOut) |-> $past(countQ) == {WIDTH{1'b1}}); // R9

endmodule

bind multi_timer16 multi_timer16_chk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .countQ(countQ), .ctlQ(ctlQ),
  .ovfFlag(ovfFlag), .extFlag(extFlag), .baudTick(baudTick),
  .countPinOut(countPinOut)
);

// File: tb/multi_timer16_test.sv
module multi_timer16_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RUN = 16'h0001, CPIN = 16'h0002, FAST = 16'h0004,
    EXTEN = 16'h0008, CAP = 16'h0010, UPDN = 16'h0020, BAUD = 16'h0040,
    CLKO = 16'h0080, KEEPOVF = 16'h0100, KEEPEXT = 16'h0200;

  logic clk = 0, rstN = 0, regWrEn = 0, countPinIn = 0, trigPinIn = 0;
  logic [1:0] regAddr = 0;
  logic [15:0] regWrData = 0, regRdData;
  logic countPinOut, countPinOe, baudTick, ovfFlag, extFlag;

  int nChecks = 0, nFails = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_timer16 uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .countPinIn(countPinIn), .trigPinIn(trigPinIn),
    .countPinOut(countPinOut), .countPinOe(countPinOe),
    .baudTick(baudTick), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cntPulse();
    @(negedge clk); countPinIn = 1; idle(5);
    countPinIn = 0; idle(5);
  endtask

  task automatic trigPulse();
    @(negedge clk); trigPinIn = 1; idle(5);
    trigPinIn = 0; idle(5);
  endtask

  function automatic logic [15:0] nextUp(input logic [15:0] c, input logic [15:0] r);
    return (c == 16'hFFFF) ? r : c + 16'd1;
  endfunction

  function automatic logic [16:0] nextUd(input logic [15:0] c, input logic [15:0] r, input bit up);
    if (up)  return (c == 16'hFFFF) ? {1'b1, r} : {1'b0, c + 16'd1};
    else     return (c == r) ? {1'b1, 16'hFFFF} : {1'b0, c - 16'd1};
  endfunction

  task automatic measPeriod(input string req, input int exp);
    logic [15:0] prev, cur;
    int last = -1, found = 0;
    rd(2'd0, prev);
    for (int cyc = 0; cyc < 120 && found < 3; cyc++) begin
      idle(1); rd(2'd0, cur);
      if (cur != prev) begin
        if (last >= 0) begin chk(req, 16'(cyc - last), 16'(exp)); found++; end
        last = cyc; prev = cur;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v, prev, rel;
    logic [16:0] nx;
    bit up, expExt, expOvf;
    int steps, gap, lastT;
    void'($urandom(32'h5EED_1234));
    idle(3); rstN = 1; idle(2);

    // R1 reset state and readback
    rd(2'd0, v); chk("R1 count reset", v, 16'h0);
    rd(2'd1, v); chk("R1 reload reset", v, 16'h0);
    rd(2'd2, v); chk("R1 ctrl reset", v, 16'h0);
    chk("R1 outputs reset", {12'h0, baudTick, ovfFlag, extFlag, countPinOe}, 16'h0);

    // R11 count write against running fast ticks
    wr(2'd2, RUN | FAST);
    rd(2'd2, v); chk("R1 ctrl readback", v, RUN | FAST);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      regWrEn = 1; regAddr = 2'd0; regWrData = 16'h1000 + 16'(i * 16'h111);
      @(negedge clk);
      rd(2'd0, v); chk("R11 write wins", v, 16'h1000 + 16'(i * 16'h111));
    end
    regWrEn = 0;

    // R2 prescale periods and hold
    measPeriod("R2 fast period", 6);
    wr(2'd2, RUN);
    measPeriod("R2 slow period", 12);
    wr(2'd2, 16'h0);
    rd(2'd0, prev); idle(40); rd(2'd0, v); chk("R2 hold when stopped", v, prev);

    // R3 count pin edges
    wr(2'd0, 16'h0); wr(2'd2, RUN | CPIN);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); countPinIn = 1; idle(5);
      rd(2'd0, v); chk("R3 rising ignored", v, 16'(i - 1));
      countPinIn = 0; idle(5);
      rd(2'd0, v); chk("R3 falling counts", v, 16'(i));
    end

    // R4 capture
    wr(2'd2, RUN | CPIN | CAP | EXTEN);
    wr(2'd0, 16'h1234);
    trigPulse();
    rd(2'd1, v); chk("R4 captured value", v, 16'h1234);
    rd(2'd0, v); chk("R4 count kept", v, 16'h1234);
    chk("R4 ext flag", {15'h0, extFlag}, 16'h1);
    chk("R4 no ovf yet", {15'h0, ovfFlag}, 16'h0);
    wr(2'd0, 16'hFFFF);
    cntPulse();
    rd(2'd0, v); chk("R4 wrap to zero", v, 16'h0000);
    chk("R4 ovf flag", {15'h0, ovfFlag}, 16'h1);

    // R5 up-only reload
    wr(2'd2, RUN | CPIN);
    chk("R10 flags cleared", {14'h0, ovfFlag, extFlag}, 16'h0);
    wr(2'd1, 16'h5A5A); wr(2'd0, 16'hFFFF);
    cntPulse();
    rd(2'd0, v); chk("R5 reload on wrap", v, 16'h5A5A);
    chk("R5 ovf flag", {15'h0, ovfFlag}, 16'h1);
    wr(2'd0, 16'h0100);
    trigPulse();
    rd(2'd0, v); chk("R5 trigger ignored", v, 16'h0100);
    chk("R5 ext not set", {15'h0, extFlag}, 16'h0);
    wr(2'd2, RUN | CPIN | EXTEN | KEEPOVF);
    trigPulse();
    rd(2'd0, v); chk("R5 trigger reload", v, 16'h5A5A);
    chk("R5 ext set", {15'h0, extFlag}, 16'h1);
    chk("R10 write 1 keeps ovf", {15'h0, ovfFlag}, 16'h1);

    // R10 stickiness and same-cycle set vs clear
    wr(2'd2, RUN | CPIN | EXTEN | KEEPEXT);
    chk("R10 ovf cleared", {15'h0, ovfFlag}, 16'h0);
    idle(20);
    chk("R10 ext sticky", {15'h0, extFlag}, 16'h1);
    wr(2'd0, 16'hFFFF);
    @(negedge clk); countPinIn = 1; idle(5);
    countPinIn = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    regWrEn = 1; regAddr = 2'd2; regWrData = RUN | CPIN;
    @(negedge clk); regWrEn = 0;
    chk("R10 set wins over clear", {15'h0, ovfFlag}, 16'h1);
    chk("R10 ext cleared", {15'h0, extFlag}, 16'h0);

    // R6/R7 random up/down walk
    wr(2'd2, UPDN | EXTEN | FAST);
    rel = 16'hFFE0 + 16'($urandom % 16);
    wr(2'd1, rel);
    wr(2'd0, rel + 16'($urandom % 8));
    trigPinIn = 1; up = 1; expExt = 0; expOvf = 0;
    idle(5);
    wr(2'd2, UPDN | EXTEN | FAST | RUN);
    rd(2'd0, prev);
    steps = 0;
    for (int cyc = 0; cyc < 3000 && steps < 80; cyc++) begin
      idle(1); rd(2'd0, v);
      if (v != prev) begin
        nx = nextUd(prev, rel, up);
        if (nx[16]) begin expExt = ~expExt; expOvf = 1; end
        chk(up ? "R6 up step" : "R7 down step", v, nx[15:0]);
        chk("R7 flags in up/down", {14'h0, ovfFlag, extFlag}, {14'h0, expOvf, expExt});
        prev = v; steps++;
        up = ($urandom % 2) == 1;
        trigPinIn = up;
      end
    end

    // R8 baud mode random reloads
    for (int it = 0; it < 4; it++) begin
      wr(2'd2, 16'h0);
      rel = 16'hFFF0 + 16'($urandom % 14);
      wr(2'd1, rel); wr(2'd0, rel);
      wr(2'd2, RUN | BAUD);
      rd(2'd0, prev); lastT = -1;
      for (int cyc = 0; cyc < 200; cyc++) begin
        idle(1); rd(2'd0, v);
        if (v != prev) begin
          chk("R8 baud step", v, nextUp(prev, rel));
          chk("R8 tick on wrap", {15'h0, baudTick}, {15'h0, prev == 16'hFFFF});
          if (lastT >= 0) begin gap = cyc - lastT; chk("R8 step period", 16'(gap), 16'd2); end
          lastT = cyc; prev = v;
        end
      end
      chk("R8 no ovf", {15'h0, ovfFlag}, 16'h0);
    end
    wr(2'd2, RUN | BAUD | EXTEN);
    trigPulse();
    chk("R8 ext by trigger", {14'h0, ovfFlag, extFlag}, 16'h1);

    // R9 clock-out
    wr(2'd2, 16'h0);
    wr(2'd1, 16'hFFFC); wr(2'd0, 16'hFFFC);
    wr(2'd2, RUN | CLKO);
    chk("R9 drive enable", {15'h0, countPinOe}, 16'h1);
    begin
      logic lastPin;
      int found = 0;
      lastPin = countPinOut; lastT = -1;
      for (int cyc = 0; cyc < 200 && found < 4; cyc++) begin
        idle(1);
        if (countPinOut != lastPin) begin
          if (lastT >= 0) begin chk("R9 toggle interval", 16'(cyc - lastT), 16'd8); found++; end
          lastT = cyc; lastPin = countPinOut;
        end
      end
      if (found == 0) chk("R9 toggles seen", 16'h0, 16'h1);
    end
    chk("R9 no ovf", {15'h0, ovfFlag}, 16'h0);

    finishRun();
  end

endmodule